// File: doc/BRIEF.md
# Masked-Tag Range Cache with Selectable Index

This block is a small set-associative lookup cache that turns a 32-bit destination address into an output interface number. Every entry stands for one aligned address range whose size is a power of two. The entry keeps a tag and its own compare mask, so one entry can cover a single host or a very large block. A masked compare therefore replaces any general range check.

The set index is not taken from the low address bits. A configuration register names K arbitrary bit positions, and the bits found at those positions form the set number. Those bits are removed from every tag compare. Software-side tooling picks the positions and merges the ranges. The cache only stores what the fill port supplies and answers lookups one cycle later. The fill logic keeps a set free of overlapping entries, so any address matches at most one way.

Top module: `range_cache`

## Requirements
- R1: After reset every entry is invalid, `lk_hit` and `lk_iface` are 0, and index field j holds the value j, so the index comes from address bits K-1..0.
- R2: Set index bit j is the address bit at the position held in `cfg_pos[5j+4:5j]`. Field 0 gives the least significant index bit. A fill goes to the set gathered from `fill_tag` in the same way.
- R3: A way matches a lookup when it is valid and the lookup address equals the stored tag on every bit where the stored mask is 1. A 1 in `fill_mask` means the bit is compared. The configured index positions are cleared from the stored mask, and the tag is stored already masked.
- R4: The result is registered. `lk_hit` and `lk_iface` change at the clock edge that samples `lk_valid` high, and they hold until the next edge. When `lk_valid` is low at an edge, `lk_hit` is 0 after that edge.
- R5: On a miss, `lk_iface` is 0. On a hit it is the interface stored with the matching way, and if several ways match, the lowest-numbered way wins.
- R6: A fill that overlaps existing valid entries of its set (they agree on all bits both masks compare) is written into the lowest overlapping way, and every other overlapping way in that set is invalidated. No two entries of a set can then match the same address.
- R7: A fill that does not overlap and does not force a way uses a round-robin pointer kept per set. The pointer starts at way 0 and advances only on such fills, wrapping after way WAYS-1.
- R8: With `fill_way_force` high, the fill writes way `fill_way`. Other overlapping ways are invalidated, and the set's round-robin pointer does not move.
- R9: A `cfg_write` loads `cfg_pos`, invalidates every entry and clears every round-robin pointer. A fill in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Address to look up |
| lk_hit | output | 1 | Registered hit flag |
| lk_iface | output | IF_W | Registered interface, 0 on miss |
| fill_valid | input | 1 | Fill request |
| fill_tag | input | 32 | Range base address |
| fill_mask | input | 32 | Compare mask, 1 = compared bit |
| fill_iface | input | IF_W | Interface for the range |
| fill_way_force | input | 1 | Use `fill_way` instead of the round-robin choice |
| fill_way | input | WAY_W | Way written when forced |
| cfg_write | input | 1 | Load index positions and flush |
| cfg_pos | input | 5*K | K five-bit index positions |

## Verification
Wrong internal state shows up at the lookup result one cycle after the lookup that touches it. A bad gather of the index bits sends a lookup to the wrong set, so an entry that was just filled gives a miss. A bad mask lets an address outside the range hit. A pointer that advances at the wrong time evicts a different entry, which is only seen at the first lookup of the lost range after the set has wrapped. For that reason the tests fill past the associativity and then probe every range. A flush that is missed leaves stale hits, which are visible on the first lookup after reconfiguration.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int ADDR_W = 32;
  localparam int POS_W1 = 5;

  // Equal on every bit that the mask selects.
  function automatic logic masked_eq(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] b,
                                     input logic [ADDR_W-1:0] m);
    return ((a ^ b) & m) == '0;
  endfunction

  // One-hot address bit for a configured index position.
  function automatic logic [ADDR_W-1:0] pos_bit(input logic [POS_W1-1:0] p);
    return ADDR_W'(1) << p;
  endfunction
endpackage

// File: rtl/rc_index_gather.sv
module rc_index_gather #(
  parameter int K = 3
) (
  input  logic [31:0]    addr,
  input  logic [5*K-1:0] pos,
  output logic [K-1:0]   idx
);
  for (genvar j = 0; j < K; j++) begin : g_bit
    assign idx[j] = addr[pos[5*j +: 5]];
  end
endmodule

// File: rtl/rc_way_match.sv
module rc_way_match (
  input  logic        valid,
  input  logic [31:0] a,
  input  logic [31:0] b,
  input  logic [31:0] m,
  output logic        match
);
  import rc_pkg::*;
  assign match = valid & masked_eq(a, b, m);
endmodule

// File: rtl/rc_rr_ptr.sv
module rc_rr_ptr #(
  parameter int SETS  = 8,
  parameter int WAYS  = 4,
  parameter int K     = 3,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             adv,
  input  logic [K-1:0]     set,
  output logic [WAY_W-1:0] ptr
);
  logic [WAY_W-1:0] ptr_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (flush) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (adv) begin
      ptr_q[set] <= (ptr_q[set] == WAY_W'(WAYS-1)) ? '0 : ptr_q[set] + 1'b1;
    end
  end

  assign ptr = ptr_q[set];
endmodule

// File: rtl/range_cache.sv
module range_cache #(
  parameter int K     = 3,
  parameter int WAYS  = 4,
  parameter int IF_W  = 4,
  parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [31:0]      lk_addr,
  output logic             lk_hit,
  output logic [IF_W-1:0]  lk_iface,
  input  logic             fill_valid,
  input  logic [31:0]      fill_tag,
  input  logic [31:0]      fill_mask,
  input  logic [IF_W-1:0]  fill_iface,
  input  logic             fill_way_force,
  input  logic [WAY_W-1:0] fill_way,
  input  logic             cfg_write,
  input  logic [5*K-1:0]   cfg_pos
);
  import rc_pkg::*;

  localparam int SETS  = 1 << K;
  localparam int POS_W = 5 * K;

  // Configuration and storage
  logic [POS_W-1:0] pos_q;
  logic [WAYS-1:0]  vld_q  [SETS];
  logic [31:0]      tag_q  [SETS][WAYS];
  logic [31:0]      mask_q [SETS][WAYS];
  logic [IF_W-1:0]  iface_q[SETS][WAYS];

  logic [31:0] idx_mask;
  always_comb begin
    idx_mask = '0;
    for (int j = 0; j < K; j++) idx_mask |= pos_bit(pos_q[5*j +: 5]);
  end

  // Lookup path
  logic [K-1:0]    lk_set;
  logic [WAYS-1:0] lk_match, win_oh;
  logic [IF_W-1:0] win_iface;

  rc_index_gather #(.K(K)) u_lk_idx (.addr(lk_addr), .pos(pos_q), .idx(lk_set));

  for (genvar w = 0; w < WAYS; w++) begin : g_lk
    rc_way_match u_m (
      .valid(vld_q[lk_set][w]), .a(lk_addr),
      .b(tag_q[lk_set][w]), .m(mask_q[lk_set][w]), .match(lk_match[w]));
  end

  assign win_oh = lk_match & (~lk_match + WAYS'(1));

  always_comb begin
    win_iface = '0;
    for (int w = 0; w < WAYS; w++)
      if (win_oh[w]) win_iface |= iface_q[lk_set][w];
  end

  logic            hit_q;
  logic [IF_W-1:0] iface_out_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q       <= 1'b0;
      iface_out_q <= '0;
    end else begin
      hit_q       <= lk_valid & (|lk_match);
      iface_out_q <= lk_valid ? win_iface : '0;
    end
  end
  assign lk_hit   = hit_q;
  assign lk_iface = iface_out_q;

  // Fill path
  logic [K-1:0]     fill_set;
  logic [31:0]      fill_mask_eff, fill_tag_eff;
  logic [WAYS-1:0]  ovl, tgt_oh, kill;
  logic [WAY_W-1:0] ovl_idx, rr_ptr, fill_tgt;
  logic             fill_do, use_rr;

  rc_index_gather #(.K(K)) u_fl_idx (.addr(fill_tag), .pos(pos_q), .idx(fill_set));

  assign fill_mask_eff = fill_mask & ~idx_mask;
  assign fill_tag_eff  = fill_tag & fill_mask_eff;

  for (genvar w = 0; w < WAYS; w++) begin : g_ovl
    rc_way_match u_o (
      .valid(vld_q[fill_set][w]), .a(fill_tag_eff),
      .b(tag_q[fill_set][w]), .m(mask_q[fill_set][w] & fill_mask_eff),
      .match(ovl[w]));
  end

  always_comb begin
    ovl_idx = '0;
    for (int w = WAYS-1; w >= 0; w--)
      if (ovl[w]) ovl_idx = WAY_W'(w);
  end

  assign fill_do  = fill_valid & ~cfg_write;
  assign use_rr   = ~fill_way_force & ~(|ovl);
  assign fill_tgt = fill_way_force ? fill_way : ((|ovl) ? ovl_idx : rr_ptr);
  assign tgt_oh   = WAYS'(1) << fill_tgt;
  assign kill     = ovl & ~tgt_oh;

  rc_rr_ptr #(.SETS(SETS), .WAYS(WAYS), .K(K), .WAY_W(WAY_W)) u_rr (
    .clk(clk), .rst_n(rst_n), .flush(cfg_write),
    .adv(fill_do & use_rr), .set(fill_set), .ptr(rr_ptr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      for (int j = 0; j < K; j++) pos_q[5*j +: 5] <= 5'(j);
    end else if (cfg_write) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      pos_q <= cfg_pos;
    end else if (fill_do) begin
      vld_q[fill_set] <= (vld_q[fill_set] & ~kill) | tgt_oh;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_do) begin
      tag_q[fill_set][fill_tgt]   <= fill_tag_eff;
      mask_q[fill_set][fill_tgt]  <= fill_mask_eff;
      iface_q[fill_set][fill_tgt] <= fill_iface;
    end
  end

  // Flattened valid bits for the checker
  logic [SETS*WAYS-1:0] vld_flat;
  for (genvar s = 0; s < SETS; s++) begin : g_flat
    assign vld_flat[s*WAYS +: WAYS] = vld_q[s];
  end
endmodule

// File: rtl/rc_checker.sv
module rc_checker #(
  parameter int K     = 3,
  parameter int WAYS  = 4,
  parameter int IF_W  = 4,
  parameter int WAY_W = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       lk_valid,
  input logic                       lk_hit,
  input logic [IF_W-1:0]            lk_iface,
  input logic                       cfg_write,
  input logic [WAYS-1:0]            lk_match,
  input logic [(1<<K)*WAYS-1:0]     vld_flat,
  input logic                       fill_do,
  input logic [K-1:0]               fill_set,
  input logic [WAY_W-1:0]           fill_tgt
);
  AST_LOOKUP_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && (|lk_match)) |=> lk_hit); // R3

  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !lk_hit); // R4

  AST_MISS_IFACE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_iface == '0)); // R5

  AST_SET_UNIQUE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match)); // R6

  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_do |=> vld_flat[int'($past(fill_set))*WAYS + int'($past(fill_tgt))]); // R7

  AST_CFG_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_write |=> (vld_flat == '0)); // R9
endmodule

bind range_cache rc_checker #(.K(K), .WAYS(WAYS), .IF_W(IF_W), .WAY_W(WAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hit(lk_hit),
  .lk_iface(lk_iface), .cfg_write(cfg_write), .lk_match(lk_match),
  .vld_flat(vld_flat), .fill_do(fill_do), .fill_set(fill_set),
  .fill_tgt(fill_tgt));

// File: tb/range_cache_tb.sv
module range_cache_tb;
  localparam int K = 3, WAYS = 4, IF_W = 4, WAY_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 1'b0, lk_hit;
  logic [31:0] lk_addr = '0;
  logic [IF_W-1:0] lk_iface;
  logic fill_valid = 1'b0, fill_way_force = 1'b0, cfg_write = 1'b0;
  logic [31:0] fill_tag = '0, fill_mask = '0;
  logic [IF_W-1:0] fill_iface = '0;
  logic [WAY_W-1:0] fill_way = '0;
  logic [5*K-1:0] cfg_pos = '0;

  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  range_cache #(.K(K), .WAYS(WAYS), .IF_W(IF_W)) u_dut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] a, input bit eh, input int ei,
                        input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    check(lk_hit == eh, req, $sformatf("hit @%h", a), lk_hit, eh);
    check(lk_iface == IF_W'(ei), req, $sformatf("iface @%h", a), lk_iface, ei);
  endtask

  task automatic fill(input logic [31:0] t, input logic [31:0] m, input int ifc,
                      input bit force_w, input int way);
    @(negedge clk);
    fill_valid = 1'b1; fill_tag = t; fill_mask = m; fill_iface = IF_W'(ifc);
    fill_way_force = force_w; fill_way = WAY_W'(way);
    @(negedge clk);
    fill_valid = 1'b0; fill_way_force = 1'b0;
  endtask

  task automatic configure(input int p0, input int p1, input int p2);
    @(negedge clk);
    cfg_write = 1'b1; cfg_pos = {5'(p2), 5'(p1), 5'(p0)};
    @(negedge clk);
    cfg_write = 1'b0;
  endtask

  task automatic t_reset();
    check(lk_hit == 1'b0, "R1", "hit after reset", lk_hit, 0);
    check(lk_iface == '0, "R1", "iface after reset", lk_iface, 0);
    lookup(32'h0000_0000, 0, 0, "R1");
  endtask

  // Default index = bits 2..0
  task automatic t_default_index();
    fill(32'h0A00_0000, 32'hFF00_0000, 5, 0, 0);   // set 0
    fill(32'h0A00_0001, 32'hFF00_0000, 2, 0, 0);   // set 1
    lookup(32'h0A12_3450, 1, 5, "R2");
    lookup(32'h0A12_3451, 1, 2, "R2");
    lookup(32'h0A12_3452, 0, 0, "R2");             // set 2 empty
    lookup(32'h0B00_0000, 0, 0, "R3");
  endtask

  // Registered latency and idle behaviour
  task automatic t_latency();
    lookup(32'h0A12_3450, 1, 5, "R4");
    #1;
    check(lk_hit == 1'b1, "R4", "held until next edge", lk_hit, 1);
    @(negedge clk);
    check(lk_hit == 1'b0, "R4", "idle edge clears hit", lk_hit, 0);
    check(lk_iface == '0, "R5", "idle iface", lk_iface, 0);
  endtask

  // Index from bits 4, 9, 20
  task automatic t_custom_index();
    configure(4, 9, 20);
    lookup(32'h0A12_3450, 0, 0, "R9");            // flushed
    fill(32'h0A00_0000, 32'hFF00_0000, 3, 0, 0);
    lookup(32'h0A0C_000F, 1, 3, "R2");
    lookup(32'h0A10_0000, 0, 0, "R2");            // bit 20 -> set 4
    fill(32'h0610_0000, 32'hFFF0_0000, 6, 0, 0);  // mask includes bit 20
    lookup(32'h0610_0000, 1, 6, "R3");
    lookup(32'h0620_0000, 0, 0, "R3");
  endtask

  task automatic t_overlap();
    configure(4, 9, 20);
    fill(32'h0C00_0000, 32'hFFFF_0000, 7, 0, 0);  // way0
    fill(32'h0C01_0000, 32'hFFFF_0000, 8, 0, 0);  // way1
    fill(32'h0A00_0000, 32'hFF00_0000, 3, 0, 0);  // way2, ptr -> 3
    lookup(32'h0C00_00AB, 1, 7, "R3");
    lookup(32'h0C01_00AB, 1, 8, "R5");
    fill(32'h0C00_0000, 32'hFF00_0000, 9, 0, 0);  // overlaps way0, way1
    lookup(32'h0C01_00AB, 1, 9, "R6");
    lookup(32'h0C00_00AB, 1, 9, "R6");
    lookup(32'h0A0C_000F, 1, 3, "R6");
    fill(32'h0D00_0000, 32'hFF00_0000, 12, 0, 0); // way3
    fill(32'h0E00_0000, 32'hFF00_0000, 13, 0, 0); // wraps to way0
    lookup(32'h0C00_00AB, 0, 0, "R7");
    lookup(32'h0E00_0000, 1, 13, "R7");
    lookup(32'h0D00_0000, 1, 12, "R7");
  endtask

  task automatic t_round_robin_force();
    configure(4, 9, 20);
    for (int i = 1; i <= 5; i++)
      fill(32'(i) << 24, 32'hFF00_0000, i, 0, 0);   // ways 0,1,2,3,0
    fill(32'h0610_0000, 32'hFFF0_0000, 6, 0, 0);    // set 4 own pointer
    lookup(32'h0100_0000, 0, 0, "R7");
    lookup(32'h0200_0000, 1, 2, "R7");
    lookup(32'h0500_0000, 1, 5, "R7");
    lookup(32'h0610_0000, 1, 6, "R7");
    fill(32'h0700_0000, 32'hFF00_0000, 10, 1, 2);   // forced way2
    lookup(32'h0300_0000, 0, 0, "R8");
    lookup(32'h0700_0000, 1, 10, "R8");
    fill(32'h0800_0000, 32'hFF00_0000, 11, 0, 0);   // pointer still at way1
    lookup(32'h0200_0000, 0, 0, "R8");
    lookup(32'h0400_0000, 1, 4, "R8");
    lookup(32'h0800_0000, 1, 11, "R8");
  endtask

  task automatic t_cfg_with_fill();
    @(negedge clk);
    cfg_write = 1'b1; cfg_pos = {5'd2, 5'd1, 5'd0};
    fill_valid = 1'b1; fill_tag = 32'h0A00_0000; fill_mask = 32'hFF00_0000;
    fill_iface = 4'd5;
    @(negedge clk);
    cfg_write = 1'b0; fill_valid = 1'b0;
    lookup(32'h0A00_0000, 0, 0, "R9");
    lookup(32'h0800_0000, 0, 0, "R9");
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_default_index();
    t_latency();
    t_custom_index();
    t_overlap();
    t_round_robin_force();
    t_cfg_with_fill();
    finish_up();
  end
endmodule